// File: doc/BRIEF.md
# Multichannel DAC Serial Register Front End

This block is the serial command port of a sixteen-channel digital-to-analog converter. A host sends 24-bit frames over a four-wire serial link, most significant bit first: a command byte and then a 16-bit data word. The block decodes each complete frame and updates a register set. Each channel has a staging register and a live code register. Shared registers hold the output range code, a dither power-down mask, a dither polarity mask, and two 32-bit dither fields, source and scale, with two bits per channel. The live codes and all dither and range settings appear in parallel on output buses, which the converter core reads directly.

The command byte carries a channel number in its low nibble for the staging-write, live-write and readback commands. Each 32-bit dither field is written in two halves by a pair of commands. A readback request takes two frames: the requested value is captured when the request frame completes and is shifted out on MISO during the next frame, which the host normally fills with a no-op. A full soft reset takes effect only when its frame carries a key word. The same clock edge that clears the registers also raises a one-cycle pulse output.

The serial pins are sampled by the system clock through two-stage synchronisers, so SCLK must run several times slower than `clk`. Frames apply only when chip select rises. A frame with any bit count other than 24 is dropped.

Top module: `mcdac_spi_regs`

## Requirements
- R1: A frame applies only when CS_N rises after exactly 24 SCLK rising edges. The command byte is bits 23..16 and the data word is bits 15..0, both received MSB first. A frame with fewer or more edges changes no register and no readback state.
- R2: Command 0x1n loads the data word into staging register n and leaves the live codes unchanged. Command 0x2n loads the data word into live code n, which appears on `dac_codes[16n+15:16n]`.
- R3: Command 0x30 copies all sixteen staging registers into the live codes. Command 0x60 writes the data word into all sixteen live codes.
- R4: After a complete frame with command 0x8n, the next frame drives MISO with 8 zero bits and then the value that live code n held when the 0x8n frame completed, MSB first. After any other complete frame, the following frame drives 24 zero bits.
- R5: Command 0x70 with data word 0x1234 returns every register to its reset value and raises `soft_rst` for exactly one clock cycle. Command 0x70 with any other data word changes nothing and gives no pulse.
- R6: Command 0x40 sets `span_code` to data bits 2..0. Codes 0 to 7 select, in order, 0..-20 V, 0..-16 V, 0..-10 V, -12..14 V, -16..10 V, -10..6 V, -5..5 V and -10..10 V.
- R7: Command 0x51 loads `dith_pwr`, where bit n = 1 powers down the dither of channel n. Command 0xB0 loads `dith_inv`, one polarity bit per channel.
- R8: Commands 0x90 and 0xA0 load bits 15..0 and bits 31..16 of `dith_src`. Commands 0xC0 and 0xD0 do the same for `dith_scl`. Channel n owns bits 2n+1..2n of each field.
- R9: While `rst_n` is low, and afterwards until the first applied frame, every output is zero except `dith_pwr`, which is all ones.
- R10: Any command byte not listed in R2 to R8, for example 0x00, 0x01, 0x35, 0x41, 0x52, 0xE0 or 0xFF, changes no register. Such a frame still clears a pending readback as R4 states.
- R11: No output register changes while CS_N is low. An applied frame reaches the outputs within four clock cycles after CS_N rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low, data sampled on its rising edge |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial readback data to host, changed after SCLK falling edges |
| dac_codes | output | 256 | Live codes, channel n in bits 16n+15..16n |
| span_code | output | 3 | Output range code |
| dith_pwr | output | 16 | Dither power-down mask |
| dith_inv | output | 16 | Dither polarity mask |
| dith_src | output | 32 | Dither source selection, 2 bits per channel |
| dith_scl | output | 32 | Dither scale selection, 2 bits per channel |
| soft_rst | output | 1 | One-cycle pulse when a keyed soft reset applies |

## Verification
The assertions assume that SCLK and CS_N move slowly against `clk`. Every SCLK half period and every CS_N high gap must last well beyond the synchroniser delay, and MOSI must be stable around each SCLK rising edge. The frame-hold property also assumes that two keyed resets can never arrive within 24 SCLK edges of each other. The bench holds each serial level for eight clock cycles and changes MOSI only together with a falling SCLK. It keeps CS_N high for at least ten cycles between frames, so every stimulus stays inside these assumptions. Short and long frames stay legal: they only vary the edge count between the CS_N transitions.

// File: rtl/mcdac_pkg.sv
// Package: shared widths, command codes and the decoded operation type for
// the multichannel DAC serial front end. Assumes an 8-bit command byte whose
// upper nibble selects the operation and lower nibble the channel.
package mcdac_pkg;

    localparam int CMD_W  = 8;
    localparam int CH_W   = 4;
    localparam int SPAN_W = 3;

    localparam logic [CMD_W-1:0] C_LOAD   = 8'h30;
    localparam logic [CMD_W-1:0] C_SPAN   = 8'h40;
    localparam logic [CMD_W-1:0] C_PWR    = 8'h51;
    localparam logic [CMD_W-1:0] C_BCAST  = 8'h60;
    localparam logic [CMD_W-1:0] C_SRST   = 8'h70;
    localparam logic [CMD_W-1:0] C_SRC_LO = 8'h90;
    localparam logic [CMD_W-1:0] C_SRC_HI = 8'hA0;
    localparam logic [CMD_W-1:0] C_INV    = 8'hB0;
    localparam logic [CMD_W-1:0] C_SCL_LO = 8'hC0;
    localparam logic [CMD_W-1:0] C_SCL_HI = 8'hD0;

    localparam logic [3:0] G_WR_IN  = 4'h1;
    localparam logic [3:0] G_WR_DAC = 4'h2;
    localparam logic [3:0] G_RDBK   = 4'h8;

    localparam logic [15:0] SRST_KEY = 16'h1234;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_WR_IN,
        OP_WR_DAC,
        OP_LOAD,
        OP_BCAST,
        OP_SPAN,
        OP_PWR,
        OP_INV,
        OP_SRC_LO,
        OP_SRC_HI,
        OP_SCL_LO,
        OP_SCL_HI,
        OP_SRST,
        OP_RDBK
    } op_e;

endpackage

// File: rtl/mcdac_frame_rx.sv
// Serial frame engine. Synchronises SCLK, CS_N and MOSI into clk, shifts in
// MOSI on SCLK rising edges, and flags a frame only if exactly FRAME_W edges
// arrived before CS_N rose. Loads tx_word at CS_N fall and shifts it out on
// MISO after each SCLK falling edge. Assumes SCLK is much slower than clk.
module mcdac_frame_rx #(
    parameter int FRAME_W     = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               miso,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_word
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(FRAME_W + 1);

    logic [SYNC_STAGES:0] sclk_p;
    logic [SYNC_STAGES:0] cs_p;
    logic [SYNC_STAGES-1:0] mosi_p;
    logic               sclk_rise, sclk_fall, cs_rise, cs_fall, cs_cur, mosi_cur;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sh;
    logic [FRAME_W-1:0] tx_sh;

    // Synchroniser chains with one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk};
            cs_p   <= {cs_p[SYNC_STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
        end
    end

    assign cs_cur    = cs_p[SYNC_STAGES-1];
    assign mosi_cur  = mosi_p[SYNC_STAGES-1];
    assign sclk_rise =  sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];
    assign sclk_fall = ~sclk_p[SYNC_STAGES-1] &  sclk_p[SYNC_STAGES];
    assign cs_rise   =  cs_p[SYNC_STAGES-1]   & ~cs_p[SYNC_STAGES];
    assign cs_fall   = ~cs_p[SYNC_STAGES-1]   &  cs_p[SYNC_STAGES];

    // Receive shift register and saturating edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (!cs_cur && sclk_rise) begin
            rx_sh <= {rx_sh[FRAME_W-2:0], mosi_cur};
            if (bit_cnt != CNT_CAP) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Transmit shift register for readback data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (cs_fall) begin
            tx_sh <= tx_word;
        end else if (!cs_cur && sclk_fall) begin
            tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        end
    end

    assign miso = tx_sh[FRAME_W-1];

    // Frame completion strobe: only an exact-length frame is passed on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_vld  <= 1'b0;
            frame_word <= '0;
        end else begin
            frame_vld <= cs_rise && (bit_cnt == CNT_FULL);
            if (cs_rise) begin
                frame_word <= rx_sh;
            end
        end
    end

endmodule

// File: rtl/mcdac_cmd_decode.sv
// Command decoder. Splits a received frame into an operation, a channel
// number and a data word. Channel-addressed groups match on the upper nibble;
// every other command needs an exact byte match. A soft reset decodes only
// with the key word. Purely combinational.
module mcdac_cmd_decode
    import mcdac_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [CMD_W+DW-1:0] word,
    output op_e                 op,
    output logic [CH_W-1:0]     ch,
    output logic [DW-1:0]       data
);

    logic [CMD_W-1:0] cmd;

    assign cmd  = word[CMD_W+DW-1 -: CMD_W];
    assign ch   = cmd[CH_W-1:0];
    assign data = word[DW-1:0];

    // Map the command byte onto an operation.
    always_comb begin
        op = OP_NONE;
        case (cmd[CMD_W-1 -: 4])
            G_WR_IN:  op = OP_WR_IN;
            G_WR_DAC: op = OP_WR_DAC;
            G_RDBK:   op = OP_RDBK;
            default: begin
                case (cmd)
                    C_LOAD:   op = OP_LOAD;
                    C_BCAST:  op = OP_BCAST;
                    C_SPAN:   op = OP_SPAN;
                    C_PWR:    op = OP_PWR;
                    C_INV:    op = OP_INV;
                    C_SRC_LO: op = OP_SRC_LO;
                    C_SRC_HI: op = OP_SRC_HI;
                    C_SCL_LO: op = OP_SCL_LO;
                    C_SCL_HI: op = OP_SCL_HI;
                    C_SRST:   op = (data[15:0] == SRST_KEY) ? OP_SRST : OP_NONE;
                    default:  op = OP_NONE;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/mcdac_reg_file.sv
// Register file. Holds one staging and one live code register per channel,
// plus range, dither power, dither polarity, and the two-half dither source
// and scale fields. Applies one decoded operation per vld strobe and captures
// readback data. Assumes NCH <= DW and NCH <= 2**CH_W.
module mcdac_reg_file
    import mcdac_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  op_e               op,
    input  logic [CH_W-1:0]   ch,
    input  logic [DW-1:0]     data,
    output logic [NCH*DW-1:0] dac_flat,
    output logic [SPAN_W-1:0] span,
    output logic [NCH-1:0]    pwr,
    output logic [NCH-1:0]    inv,
    output logic [2*NCH-1:0]  src,
    output logic [2*NCH-1:0]  scl,
    output logic [DW-1:0]     rb_word,
    output logic              soft_rst
);

    logic            srst_now;
    logic [DW-1:0]   in_q  [NCH];
    logic [DW-1:0]   dac_q [NCH];

    assign srst_now = vld && (op == OP_SRST);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Per-channel staging and live code registers.
        always_ff @(posedge clk) begin
            if (!rst_n || srst_now) begin
                in_q[g]  <= '0;
                dac_q[g] <= '0;
            end else if (vld) begin
                case (op)
                    OP_WR_IN:  if (ch == CH_W'(g)) in_q[g] <= data;
                    OP_WR_DAC: if (ch == CH_W'(g)) dac_q[g] <= data;
                    OP_LOAD:   dac_q[g] <= in_q[g];
                    OP_BCAST:  dac_q[g] <= data;
                    default:   ;
                endcase
            end
        end
        assign dac_flat[g*DW +: DW] = dac_q[g];
    end

    // Shared range and dither registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_now) begin
            span <= '0;
            pwr  <= '1;
            inv  <= '0;
            src  <= '0;
            scl  <= '0;
        end else if (vld) begin
            case (op)
                OP_SPAN:   span <= data[SPAN_W-1:0];
                OP_PWR:    pwr <= data[NCH-1:0];
                OP_INV:    inv <= data[NCH-1:0];
                OP_SRC_LO: src[NCH-1:0] <= data[NCH-1:0];
                OP_SRC_HI: src[2*NCH-1:NCH] <= data[NCH-1:0];
                OP_SCL_LO: scl[NCH-1:0] <= data[NCH-1:0];
                OP_SCL_HI: scl[2*NCH-1:NCH] <= data[NCH-1:0];
                default:   ;
            endcase
        end
    end

    // Readback capture: valid for exactly the frame after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_word <= '0;
        end else if (vld) begin
            if (op == OP_RDBK && int'(ch) < NCH) begin
                rb_word <= dac_q[ch];
            end else begin
                rb_word <= '0;
            end
        end
    end

    // One-cycle pulse in the cycle the soft clear takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= srst_now;
        end
    end

endmodule

// File: rtl/mcdac_spi_regs.sv
// Top level of the multichannel DAC serial register front end. Connects the
// frame engine, the command decoder and the register file. Readback words go
// out with a zero command byte in front.
module mcdac_spi_regs
    import mcdac_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [NCH*DW-1:0] dac_codes,
    output logic [SPAN_W-1:0] span_code,
    output logic [NCH-1:0]    dith_pwr,
    output logic [NCH-1:0]    dith_inv,
    output logic [2*NCH-1:0]  dith_src,
    output logic [2*NCH-1:0]  dith_scl,
    output logic              soft_rst
);

    localparam int FRAME_W = CMD_W + DW;

    logic               frame_vld;
    logic [FRAME_W-1:0] frame_word;
    logic [FRAME_W-1:0] tx_word;
    logic [DW-1:0]      rb_word;
    op_e                dec_op;
    logic [CH_W-1:0]    dec_ch;
    logic [DW-1:0]      dec_data;

    assign tx_word = {{CMD_W{1'b0}}, rb_word};

    mcdac_frame_rx #(
        .FRAME_W    (FRAME_W),
        .SYNC_STAGES(2)
    ) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .tx_word   (tx_word),
        .miso      (miso),
        .frame_vld (frame_vld),
        .frame_word(frame_word)
    );

    mcdac_cmd_decode #(
        .DW(DW)
    ) dec_i (
        .word(frame_word),
        .op  (dec_op),
        .ch  (dec_ch),
        .data(dec_data)
    );

    mcdac_reg_file #(
        .NCH(NCH),
        .DW (DW)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (frame_vld),
        .op      (dec_op),
        .ch      (dec_ch),
        .data    (dec_data),
        .dac_flat(dac_codes),
        .span    (span_code),
        .pwr     (dith_pwr),
        .inv     (dith_inv),
        .src     (dith_src),
        .scl     (dith_scl),
        .rb_word (rb_word),
        .soft_rst(soft_rst)
    );

endmodule

// File: rtl/mcdac_spi_regs_chk.sv
// Checker for the serial register front end, bound to the top level. Watches
// the completed-frame strobe and word and relates them to the outputs one
// cycle later. Assumes slow serial pins as stated in the brief.
module mcdac_spi_regs_chk #(
    parameter int NCH     = 16,
    parameter int DW      = 16,
    parameter int FRAME_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               frame_vld,
    input logic [FRAME_W-1:0] frame_word,
    input logic [NCH*DW-1:0]  dac_codes,
    input logic [NCH-1:0]     dith_pwr,
    input logic [2:0]         span_code,
    input logic               soft_rst
);

    logic [4:0]         cs_hist;
    logic               last_vld;
    logic [FRAME_W-1:0] last_word;
    logic               all_match;
    logic [3:0]         last_ch;
    logic [7:0]         last_cmd;
    logic [DW-1:0]      last_data;

    // History of CS_N samples and the previous frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_hist   <= '1;
            last_vld  <= 1'b0;
            last_word <= '0;
        end else begin
            cs_hist   <= {cs_hist[3:0], cs_n};
            last_vld  <= frame_vld;
            last_word <= frame_word;
        end
    end

    assign last_cmd  = last_word[FRAME_W-1 -: 8];
    assign last_ch   = last_word[DW+3:DW];
    assign last_data = last_word[DW-1:0];

    // True when every live code equals the previous frame's data word.
    always_comb begin
        all_match = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (dac_codes[i*DW +: DW] != last_data) all_match = 1'b0;
        end
    end

    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst); // R5

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (dith_pwr == '1 && span_code == '0 && dac_codes == '0)); // R5

    AST_SRST_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        (last_vld && last_cmd == 8'h70 && last_data != 16'h1234) |-> !soft_rst); // R5

    AST_DAC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (last_vld && last_cmd[7:4] == 4'h2 && int'(last_ch) < NCH)
        |-> dac_codes[int'(last_ch)*DW +: DW] == last_data); // R2

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (last_vld && last_cmd == 8'h60) |-> all_match); // R3

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hist == 5'b0) |-> ($stable(dac_codes) && $stable(dith_pwr) && $stable(span_code))); // R11

endmodule

bind mcdac_spi_regs mcdac_spi_regs_chk #(
    .NCH    (NCH),
    .DW     (DW),
    .FRAME_W(FRAME_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .frame_vld (frame_vld),
    .frame_word(frame_word),
    .dac_codes (dac_codes),
    .dith_pwr  (dith_pwr),
    .span_code (span_code),
    .soft_rst  (soft_rst)
);

// File: tb/mcdac_spi_regs_tb_top.sv
`timescale 1ns/1ps
module mcdac_spi_regs_tb_top;

    localparam int NCH = 16;
    localparam int DW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [NCH*DW-1:0] dac_codes;
    logic [2:0]        span_code;
    logic [NCH-1:0]    dith_pwr, dith_inv;
    logic [2*NCH-1:0]  dith_src, dith_scl;
    logic              soft_rst;

    always #2.5 clk = ~clk;

    mcdac_spi_regs #(.NCH(NCH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .dac_codes(dac_codes), .span_code(span_code),
        .dith_pwr(dith_pwr), .dith_inv(dith_inv), .dith_src(dith_src),
        .dith_scl(dith_scl), .soft_rst(soft_rst)
    );

    // Behavioural reference state.
    logic [15:0] m_in  [16];
    logic [15:0] m_dac [16];
    logic [2:0]  m_span;
    logic [15:0] m_pwr, m_inv;
    logic [31:0] m_src, m_scl;
    logic [23:0] m_rb;
    int          m_srst = 0;
    int          srst_seen = 0;
    int          vectors = 0;
    int          miscompares = 0;
    bit          settled = 1'b0;
    bit          done = 1'b0;
    string       cur_tag = "R9";

    always @(posedge clk) if (soft_rst) srst_seen++;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        vectors++;
        for (int c = 0; c < NCH; c++)
            chk(tag, $sformatf("dac%0d", c), 32'(dac_codes[c*DW +: DW]), 32'(m_dac[c]));
        chk(tag, "span", 32'(span_code), 32'(m_span));
        chk(tag, "pwr", 32'(dith_pwr), 32'(m_pwr));
        chk(tag, "inv", 32'(dith_inv), 32'(m_inv));
        chk(tag, "src", dith_src, m_src);
        chk(tag, "scl", dith_scl, m_scl);
        chk(tag, "srst_pulses", 32'(srst_seen), 32'(m_srst));
    endtask

    // Compare the reference on every clock while no frame is being applied.
    always @(negedge clk) if (settled && rst_n && !done) compare_all(cur_tag);

    task automatic model_reset();
        for (int c = 0; c < 16; c++) begin m_in[c] = '0; m_dac[c] = '0; end
        m_span = '0; m_pwr = '1; m_inv = '0; m_src = '0; m_scl = '0;
    endtask

    task automatic model_apply(input logic [7:0] c, input logic [15:0] d);
        logic [23:0] nrb;
        nrb = (c[7:4] == 4'h8) ? {8'h00, m_dac[c[3:0]]} : 24'h0;
        case (c[7:4])
            4'h1: m_in[c[3:0]] = d;
            4'h2: m_dac[c[3:0]] = d;
            default: begin
                if (c == 8'h30) for (int k = 0; k < 16; k++) m_dac[k] = m_in[k];
                else if (c == 8'h60) for (int k = 0; k < 16; k++) m_dac[k] = d;
                else if (c == 8'h40) m_span = d[2:0];
                else if (c == 8'h51) m_pwr = d;
                else if (c == 8'hB0) m_inv = d;
                else if (c == 8'h90) m_src[15:0] = d;
                else if (c == 8'hA0) m_src[31:16] = d;
                else if (c == 8'hC0) m_scl[15:0] = d;
                else if (c == 8'hD0) m_scl[31:16] = d;
                else if (c == 8'h70 && d == 16'h1234) begin model_reset(); m_srst++; end
            end
        endcase
        m_rb = nrb;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] c, input logic [15:0] d, input int nbits);
        logic [23:0] w, got, exp_rb;
        w = {c, d}; got = '0; exp_rb = m_rb;
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'b0;
            tick(8);
            if (i < 24) got[23-i] = miso;
            sclk = 1'b1;
            tick(8);
            sclk = 1'b0;
        end
        tick(8);
        cs_n = 1'b1;
        settled = 1'b0;
        tick(10);
        if (nbits == 24) begin
            vectors++;
            chk("R4", $sformatf("miso frame after cmd %h", c), 32'(got), 32'(exp_rb));
            model_apply(c, d);
        end
        settled = 1'b1;
        tick(2);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_reset();
        m_rb = '0;
        tick(4);
        // R9: values during and right after reset
        vectors++;
        chk("R9", "pwr in reset", 32'(dith_pwr), 32'hFFFF);
        chk("R9", "miso in reset", 32'(miso), 32'h0);
        rst_n = 1'b1;
        tick(2);
        compare_all("R9");
        settled = 1'b1;

        // R2: staging write is invisible, live writes land per channel
        cur_tag = "R2";
        send(8'h13, 16'hA5A5, 24);
        send(8'h20, 16'h1111, 24);
        send(8'h2F, 16'hFFFF, 24);
        send(8'h27, 16'h8001, 24);
        compare_all("R2");

        // R3: software load and broadcast
        cur_tag = "R3";
        send(8'h10, 16'h0102, 24);
        send(8'h1F, 16'hF00F, 24);
        send(8'h30, 16'h0000, 24);
        compare_all("R3");
        send(8'h60, 16'h5AC3, 24);
        compare_all("R3");
        send(8'h18, 16'h7777, 24);
        send(8'h30, 16'hDEAD, 24);
        compare_all("R3");

        // R4: readback pipeline, including back-to-back requests
        cur_tag = "R4";
        send(8'h25, 16'hC3A5, 24);
        send(8'h85, 16'h0000, 24);
        send(8'h00, 16'h0000, 24);
        send(8'h8F, 16'h0000, 24);
        send(8'h80, 16'h0000, 24);
        send(8'h00, 16'h0000, 24);
        send(8'h00, 16'h0000, 24);

        // R6, R7, R8: range and dither registers
        cur_tag = "R6";
        send(8'h40, 16'hFFFD, 24);
        compare_all("R6");
        send(8'h40, 16'h0003, 24);
        cur_tag = "R7";
        send(8'h51, 16'h00F0, 24);
        send(8'hB0, 16'h8001, 24);
        compare_all("R7");
        cur_tag = "R8";
        send(8'h90, 16'h1B2C, 24);
        send(8'hA0, 16'hE4D5, 24);
        send(8'hC0, 16'h3333, 24);
        send(8'hD0, 16'hCCCC, 24);
        compare_all("R8");

        // R10: unlisted commands change nothing but do clear readback
        cur_tag = "R10";
        send(8'h82, 16'h0000, 24);
        send(8'h01, 16'hFFFF, 24);
        send(8'h00, 16'h0000, 24);
        send(8'h35, 16'h1234, 24);
        send(8'h41, 16'h0007, 24);
        send(8'h52, 16'h0000, 24);
        send(8'hE0, 16'hFFFF, 24);
        send(8'hFF, 16'hFFFF, 24);
        compare_all("R10");

        // R1: short and long frames are dropped, readback state kept
        cur_tag = "R1";
        send(8'h8F, 16'h0000, 24);
        send(8'h23, 16'h4444, 10);
        send(8'h23, 16'h4444, 23);
        send(8'h23, 16'h4444, 25);
        send(8'h00, 16'h0000, 24);
        compare_all("R1");

        // R11: outputs hold during frames; checked on every clock above
        cur_tag = "R11";
        send(8'h29, 16'h9999, 24);
        send(8'h60, 16'h0F0F, 24);

        // R5: keyed soft reset
        cur_tag = "R5";
        send(8'h70, 16'h1233, 24);
        send(8'h70, 16'h0000, 24);
        compare_all("R5");
        send(8'h70, 16'h1234, 24);
        compare_all("R5");
        send(8'h22, 16'h0042, 24);
        compare_all("R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule